// File: doc/BRIEF.md
# Serial Bit-Rate Timer with Majority Receive Sampler

This block derives the bit timing of a serial port from the system clock. An 8-bit divisor value X, loaded through a write strobe, sets a free-running counter that produces one "unit" every X+1 clocks. A postscaler then turns units into bit periods. It uses 64 units per bit in slow asynchronous mode, 16 units per bit in fast asynchronous mode, and 4 units per bit in synchronous mode. The block outputs a one-cycle bit strobe once per bit period. In asynchronous modes it also outputs a 16x oversampling strobe, which a receiver uses to find the middle of each bit.

The receive line first passes through a synchronizer. A phase counter counts oversampling strobes from the moment the receiver pulses its restart input. Three samples are taken in the middle of the bit, and their majority is presented together with a one-cycle valid pulse.

Loading the divisor, changing the effective mode, or dropping the master enable clears every counter. A new rate therefore starts from a full period. The receive result is a plain strobe with no ready input. A consumer cannot stall it and must capture it in the cycle in which the valid pulse is high.

Top module: `baud_timer`

## Requirements
- R1: With sync_mode=0 and fast_sel=0, bit_tick pulses every 64*(X+1) clocks and ovs_tick pulses 16 times per bit period. For example, X=25 gives a 1664-clock bit period.
- R2: With sync_mode=0 and fast_sel=1, bit_tick pulses every 16*(X+1) clocks and ovs_tick pulses 16 times per bit period.
- R3: With sync_mode=1, bit_tick pulses every 4*(X+1) clocks and ovs_tick stays low. The value of fast_sel has no effect, and toggling it mid-period does not disturb the period.
- R4: While master_en=0, bit_tick and ovs_tick stay low and the counters are held at zero. When master_en rises, the first bit_tick arrives in the cycle whose index is P-1, where P is the bit period and the cycle in which master_en rises is index 0.
- R5: A div_wr pulse loads div_val and clears the counters. Let index 0 be the cycle after the write cycle. The first bit_tick then arrives in cycle index P-1 of the new period, and no bit_tick occurs in the write cycle or the cycle after it.
- R6: A change of the effective mode clears the counters in the same way as a divisor write. The effective mode is slow asynchronous, fast asynchronous, or synchronous.
- R7: During and right after reset, bit_tick, ovs_tick and rx_valid are low.
- R8: rx_pin passes through a two-flop synchronizer. After rx_restart, rx_pin is sampled on the 7th, 8th and 9th ovs_tick, and rx_bit is the majority of those three samples.
- R9: rx_valid is high for exactly one cycle, namely the cycle after the 9th ovs_tick. In that cycle rx_bit carries the vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Divisor write strobe |
| div_val | input | 8 | Divisor value X |
| fast_sel | input | 1 | Fast asynchronous rate select (16 units per bit instead of 64) |
| sync_mode | input | 1 | 1 = synchronous (4 units per bit), 0 = asynchronous |
| master_en | input | 1 | Internal clock master enable |
| rx_pin | input | 1 | Asynchronous receive line |
| rx_restart | input | 1 | Restarts the receive phase counter |
| bit_tick | output | 1 | One-cycle strobe per bit period |
| ovs_tick | output | 1 | 16x oversampling strobe (asynchronous modes only) |
| rx_bit | output | 1 | Majority-voted receive level |
| rx_valid | output | 1 | One-cycle pulse marking a new rx_bit |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, 16 oversamples per bit, a slow multiplier of 4, 4 synchronous units, and two synchronizer stages. With these values the rate table can reach both divisor extremes, 0 and 255, in every mode. This includes the 1664-clock example and the longest period of 16384 clocks. With X=3 in fast mode the oversampling strobe is four clocks apart. That spacing lets the bench place each of the three votes on a known strobe through the synchronizer latency, and the majority cases are exercised that way.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    RM_SLOW = 2'd0,
    RM_FAST = 2'd1,
    RM_SYNC = 2'd2
  } rate_mode_e;
endpackage

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             unit_tick
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit = (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (hit)  cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign unit_tick = hit && !clr;
endmodule

// File: rtl/baud_postscale.sv
module baud_postscale
  import baud_pkg::*;
#(
  parameter int OVS_RATE   = 16,
  parameter int SLOW_MUL   = 4,
  parameter int SYNC_UNITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       unit_tick,
  input  rate_mode_e mode,
  output logic       bit_tick,
  output logic       ovs_tick
);
  localparam int LIM_SLOW = OVS_RATE * SLOW_MUL;
  localparam int CNT_W    = $clog2(LIM_SLOW);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             wrap;
  logic             slow_hit;

  always_comb begin
    case (mode)
      RM_SLOW: last = CNT_W'(LIM_SLOW - 1);
      RM_FAST: last = CNT_W'(OVS_RATE - 1);
      default: last = CNT_W'(SYNC_UNITS - 1);
    endcase
  end

  assign wrap     = (cnt == last);
  assign slow_hit = ((cnt % CNT_W'(SLOW_MUL)) == CNT_W'(SLOW_MUL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (unit_tick)  cnt <= wrap ? '0 : cnt + 1'b1;
  end

  assign bit_tick = unit_tick && wrap;

  always_comb begin
    case (mode)
      RM_SLOW: ovs_tick = unit_tick && slow_hit;
      RM_FAST: ovs_tick = unit_tick;
      default: ovs_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_majority.sv
module rx_majority #(
  parameter int SYNC_STAGES = 2,
  parameter int OVS_RATE    = 16,
  parameter int VOTE_AT     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic restart,
  input  logic rx_pin,
  input  logic ovs_tick,
  output logic rx_bit,
  output logic rx_valid
);
  localparam int PH_W = $clog2(OVS_RATE);

  logic [SYNC_STAGES-1:0] chain;
  logic                   rx_s;
  logic [PH_W-1:0]        phase;
  logic [1:0]             smp;
  logic                   in_win;
  logic                   last_s;
  logic                   vote;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= rx_pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign rx_s   = chain[SYNC_STAGES-1];
  assign in_win = ovs_tick && (phase >= PH_W'(VOTE_AT)) && (phase <= PH_W'(VOTE_AT + 2));
  assign last_s = ovs_tick && (phase == PH_W'(VOTE_AT + 2));
  assign vote   = (smp[1] & smp[0]) | (smp[1] & rx_s) | (smp[0] & rx_s);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || restart) begin
      phase <= '0;
      smp   <= '0;
    end else begin
      if (ovs_tick) phase <= (phase == PH_W'(OVS_RATE - 1)) ? '0 : phase + 1'b1;
      if (in_win)   smp   <= {smp[0], rx_s};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_bit   <= 1'b1;
    end else begin
      rx_valid <= last_s && !clr && !restart;
      if (last_s) rx_bit <= vote;
    end
  end
endmodule

// File: rtl/baud_timer.sv
module baud_timer
  import baud_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int OVS_RATE    = 16,
  parameter int SLOW_MUL    = 4,
  parameter int SYNC_UNITS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  input  logic             fast_sel,
  input  logic             sync_mode,
  input  logic             master_en,
  input  logic             rx_pin,
  input  logic             rx_restart,
  output logic             bit_tick,
  output logic             ovs_tick,
  output logic             rx_bit,
  output logic             rx_valid
);
  localparam int VOTE_AT = OVS_RATE / 2 - 2;

  logic [DIV_W-1:0] div_q;
  rate_mode_e       mode, mode_q;
  logic             clr;
  logic             unit_tick;

  assign mode = sync_mode ? RM_SYNC : (fast_sel ? RM_FAST : RM_SLOW);
  assign clr  = div_wr || (mode != mode_q) || !master_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= RM_SLOW;
    end else begin
      mode_q <= mode;
      if (div_wr) div_q <= div_val;
    end
  end

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .div(div_q), .unit_tick(unit_tick)
  );

  baud_postscale #(
    .OVS_RATE(OVS_RATE), .SLOW_MUL(SLOW_MUL), .SYNC_UNITS(SYNC_UNITS)
  ) u_post (
    .clk(clk), .rst_n(rst_n), .clr(clr), .unit_tick(unit_tick), .mode(mode),
    .bit_tick(bit_tick), .ovs_tick(ovs_tick)
  );

  rx_majority #(
    .SYNC_STAGES(SYNC_STAGES), .OVS_RATE(OVS_RATE), .VOTE_AT(VOTE_AT)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .restart(rx_restart), .rx_pin(rx_pin),
    .ovs_tick(ovs_tick), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/baud_timer_chk.sv
module baud_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic div_wr,
  input logic sync_mode,
  input logic master_en,
  input logic bit_tick,
  input logic ovs_tick,
  input logic rx_valid
);
  p_no_ovs_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> !ovs_tick);

  p_quiet_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (!bit_tick && !ovs_tick));

  p_write_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> !bit_tick);

  p_bit_on_ovs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !sync_mode) |-> ovs_tick);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind baud_timer baud_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .sync_mode(sync_mode),
  .master_en(master_en), .bit_tick(bit_tick), .ovs_tick(ovs_tick),
  .rx_valid(rx_valid)
);

// File: tb/baud_timer_tb.sv
`timescale 1ns/1ps
module baud_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_wr = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic       fast_sel = 1'b0;
  logic       sync_mode = 1'b1;
  logic       master_en = 1'b1;
  logic       rx_pin = 1'b1;
  logic       rx_restart = 1'b0;
  logic       bit_tick, ovs_tick, rx_bit, rx_valid;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  baud_timer u_dut (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val),
    .fast_sel(fast_sel), .sync_mode(sync_mode), .master_en(master_en),
    .rx_pin(rx_pin), .rx_restart(rx_restart), .bit_tick(bit_tick),
    .ovs_tick(ovs_tick), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  // rate table: sync, fast, X, bit period, ovs strobes per period
  localparam int NV = 10;
  localparam int VS [NV] = '{0, 0, 1, 1, 0, 0, 1, 0, 1, 0};
  localparam int VF [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 0};
  localparam int VX [NV] = '{25, 25, 25, 25, 0, 0, 0, 255, 255, 255};
  localparam int VP [NV] = '{1664, 416, 104, 104, 64, 16, 4, 4096, 1024, 16384};
  localparam int VO [NV] = '{16, 16, 0, 0, 16, 16, 0, 16, 0, 16};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic write_div(input int x);
    @(negedge clk);
    div_val = 8'(x);
    div_wr  = 1'b1;
    @(negedge clk);
    div_wr  = 1'b0;
  endtask

  // counts from the current negedge (index 0) to the first bit_tick
  task automatic to_tick(output int n);
    n = 0;
    while (!bit_tick) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic period(output int n, output int o);
    n = 0;
    o = 0;
    do begin
      @(negedge clk);
      n++;
      if (ovs_tick) o++;
    end while (!bit_tick);
  endtask

  task automatic vote(input logic [2:0] p, input string tag);
    int   k;
    logic exp;
    exp = (p[0] & p[1]) | (p[0] & p[2]) | (p[1] & p[2]);
    rx_pin = ~exp;
    while (!ovs_tick) @(negedge clk);
    @(negedge clk);
    rx_restart = 1'b1;
    @(negedge clk);
    rx_restart = 1'b0;
    k = 0;
    while (k < 9) begin
      @(negedge clk);
      if (ovs_tick) begin
        k++;
        if (k == 6) rx_pin = p[2];
        if (k == 7) rx_pin = p[1];
        if (k == 8) rx_pin = p[0];
      end
    end
    chk({tag, " R9 no early valid"}, int'(rx_valid), 0);
    @(negedge clk);
    chk({tag, " R9 valid after 9th"}, int'(rx_valid), 1);
    chk({tag, " R8 majority"}, int'(rx_bit), int'(exp));
    @(negedge clk);
    chk({tag, " R9 single pulse"}, int'(rx_valid), 0);
  endtask

  initial begin
    int n, o;
    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 bit_tick in reset", int'(bit_tick), 0);
    chk("R7 ovs_tick in reset", int'(ovs_tick), 0);
    chk("R7 rx_valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 bit_tick after reset", int'(bit_tick), 0);
    chk("R7 rx_valid after reset", int'(rx_valid), 0);

    // rate table walk: R1 R2 R3, with R5 first-tick timing
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sync_mode = VS[i][0];
      fast_sel  = VF[i][0];
      write_div(VX[i]);
      to_tick(n);
      chk($sformatf("R5 first tick vec%0d", i), n, VP[i] - 1);
      period(n, o);
      chk($sformatf("%s period vec%0d", VS[i] != 0 ? "R3" : (VF[i] != 0 ? "R2" : "R1"), i), n, VP[i]);
      chk($sformatf("%s ovs count vec%0d", VS[i] != 0 ? "R3" : "R1", i), o, VO[i]);
    end

    // R3: fast_sel toggled mid-period in sync mode has no effect
    @(negedge clk);
    sync_mode = 1'b1;
    fast_sel  = 1'b0;
    write_div(2);
    to_tick(n);
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    fast_sel = 1'b1;
    while (!bit_tick) begin @(negedge clk); n++; end
    chk("R3 fast_sel ignored", n, 12);

    // R6: mode change mid-period restarts the count
    @(negedge clk);
    sync_mode = 1'b0;
    fast_sel  = 1'b0;
    write_div(25);
    repeat (700) @(negedge clk);
    fast_sel = 1'b1;
    @(negedge clk);
    to_tick(n);
    chk("R6 restart on mode change", n, 415);

    // R4: master enable low gives no strobes, restart on enable
    @(negedge clk);
    write_div(3);
    master_en = 1'b0;
    o = 0;
    repeat (300) begin @(negedge clk); if (bit_tick || ovs_tick) o++; end
    chk("R4 quiet while disabled", o, 0);
    master_en = 1'b1;
    to_tick(n);
    chk("R4 first tick on enable", n, 63);

    // R8/R9: majority sampling, fast async X=3
    vote(3'b000, "v000");
    vote(3'b011, "v011");
    vote(3'b101, "v101");
    vote(3'b100, "v100");
    vote(3'b111, "v111");
    vote(3'b010, "v010");

    finish_run();
  end
endmodule